// File: doc/BRIEF.md
# Auto-Incrementing Receive Buffer Read Pointer

This block gives a host a byte-addressed read window into a 2 KiB receive frame buffer. The host programs an 11-bit read pointer and two mode bits through a 16-bit control register. Each data read returns the buffer contents starting at the pointer. The width of a read is one, two or four bytes. Multi-byte reads come out in little-endian or big-endian lane order, chosen by the endian mode bit.

With auto-increment on, every data read moves the pointer forward by the number of bytes it returned. A whole frame can then be drained with back-to-back reads. The host writes the pointer to zero before each such bulk read. With auto-increment off, the pointer stays put until the host writes it again. A byte-wide write port lets the receive side fill the buffer. That side is modelled here only as a plain write port.

Top module: `rxp_top`

## Requirements
- R1: After reset the pointer is 0, both mode bits are 0, `cfg_rdata` is 0 and `data_valid` is low, so a first byte read returns the byte at address 0.
- R2: A `cfg_wr` loads the pointer from `cfg_wdata[10:0]`, auto-increment from `cfg_wdata[14]` and endian mode from `cfg_wdata[11]`. `cfg_rdata` shows auto-increment on bit 14 and endian mode on bit 11, and every other bit, the pointer field included, reads as 0.
- R3: A read accepted at a clock edge (`data_rd` high) raises `data_valid` for exactly one cycle after that edge. It presents `data_rdata` taken from the addresses that start at the pointer value held before that edge.
- R4: With auto-increment set, each accepted read adds to the pointer according to `data_size`: 2'b00 adds 1, 2'b01 adds 2, 2'b10 adds 4, and 2'b11 is treated as a byte read that adds 1.
- R5: With auto-increment clear, data reads leave the pointer unchanged, so repeated reads return the same data.
- R6: The pointer and the byte addresses inside a multi-byte read wrap modulo 2048.
- R7: Byte reads return the byte on bits 7:0. For a multi-byte read with endian mode 0, the byte at the lowest address is on bits 7:0 and later bytes go to higher lanes. With endian mode 1 the lowest-address byte is on the top lane of the access width. Lanes above the access width read 0. The endian mode in force at the accepting edge applies.
- R8: When `cfg_wr` and `data_rd` arrive in the same cycle, the read uses the old pointer and old endian mode. The pointer then takes the written value, and no increment is added.
- R9: A byte written through `buf_we`/`buf_waddr`/`buf_wdata` is returned by any read accepted at a later edge that covers that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value |
| cfg_rdata | output | 16 | Control register read value |
| data_rd | input | 1 | Data read request, accepted every cycle it is high |
| data_size | input | 2 | Read width: 00 byte, 01 word, 10 double word, 11 byte |
| data_rdata | output | 32 | Read data, valid with `data_valid` |
| data_valid | output | 1 | Read data valid, one cycle after acceptance |
| buf_we | input | 1 | Buffer byte write enable |
| buf_waddr | input | 11 | Buffer byte write address |
| buf_wdata | input | 8 | Buffer byte write data |

## Verification
The checker assumes that `data_size` and `cfg_wdata` carry known values whenever their strobes are high. It also assumes that a buffer write never targets a byte that a read accepted in the same cycle covers. The bench fills the buffer before any data read. It changes buffer contents only in cycles with no read in flight, and it holds every input at a defined value from reset onward. In the cycles where the control write and the read strobe are raised together, only those two collide. No buffer write joins them.

// File: rtl/rxp_pkg.sv
// Package rxp_pkg
// Shared types and helpers for the receive buffer read pointer.
// Assumes byte-addressed storage and at most four byte lanes per read.
package rxp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_ALT   = 2'b11
    } acc_size_e;

    localparam int LANES = 4;

    // Number of bytes a read of the given width covers.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_WORD:  size_bytes = 3'd2;
            SZ_DWORD: size_bytes = 3'd4;
            default:  size_bytes = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/rxp_ctrl_reg.sv
// Module rxp_ctrl_reg
// Holds the read pointer and the two mode bits, and forms the register
// read value. A host write takes priority over an increment in the same
// cycle. Assumes the pointer fits below the mode bit positions.
module rxp_ctrl_reg
    import rxp_pkg::*;
#(
    parameter int PTR_W    = 11,
    parameter int REG_W    = 16,
    parameter int AUTO_BIT = 14,
    parameter int END_BIT  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             wr_auto,
    input  logic             wr_end,
    input  logic             rd_go,
    input  logic [1:0]       rd_size,
    output logic [PTR_W-1:0] ptr,
    output logic             auto_en,
    output logic             big_end,
    output logic [REG_W-1:0] cfg_rdata
);

    logic [PTR_W-1:0] step;

    // Widen the per-read byte count to pointer width.
    always_comb begin
        step = PTR_W'(size_bytes(rd_size));
    end

    // Pointer and mode bit state: write wins, else advance on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            auto_en <= 1'b0;
            big_end <= 1'b0;
        end else if (cfg_wr) begin
            ptr     <= wr_ptr;
            auto_en <= wr_auto;
            big_end <= wr_end;
        end else if (rd_go && auto_en) begin
            ptr     <= ptr + step;
        end
    end

    // Register read value: mode bits only, pointer hidden.
    always_comb begin
        cfg_rdata           = '0;
        cfg_rdata[AUTO_BIT] = auto_en;
        cfg_rdata[END_BIT]  = big_end;
    end

endmodule

// File: rtl/rxp_lane_buf.sv
// Module rxp_lane_buf
// Byte buffer split across LANES banks by the low address bits, so that
// LANES consecutive bytes starting at any address are fetched in one
// cycle. Read data is registered and returned in address order (element
// 0 = byte at rd_addr). Assumes no same-cycle write to a byte being read.
module rxp_lane_buf
    import rxp_pkg::*;
#(
    parameter int PTR_W = 11
) (
    input  logic                  clk,
    input  logic                  buf_we,
    input  logic [PTR_W-1:0]      buf_waddr,
    input  logic [7:0]            buf_wdata,
    input  logic                  rd_en,
    input  logic [PTR_W-1:0]      rd_addr,
    output logic [LANES-1:0][7:0] rd_bytes
);

    localparam int BANK_W = $clog2(LANES);
    localparam int ROW_W  = PTR_W - BANK_W;
    localparam int DEPTH  = 2 ** ROW_W;

    logic [LANES-1:0][7:0] bank_q;
    logic [BANK_W-1:0]     base_q;

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [7:0]        mem [DEPTH];
        logic [BANK_W-1:0] ofs;
        logic [PTR_W-1:0]  baddr;

        // Offset of this bank from the first byte of the read.
        always_comb begin
            ofs   = BANK_W'(b) - rd_addr[BANK_W-1:0];
            baddr = rd_addr + PTR_W'(ofs);
        end

        // Bank write from the fill side.
        always_ff @(posedge clk) begin
            if (buf_we && buf_waddr[BANK_W-1:0] == BANK_W'(b))
                mem[buf_waddr[PTR_W-1:BANK_W]] <= buf_wdata;
        end

        // Bank read register.
        always_ff @(posedge clk) begin
            if (rd_en)
                bank_q[b] <= mem[baddr[PTR_W-1:BANK_W]];
        end
    end

    // Remember which bank held the first byte.
    always_ff @(posedge clk) begin
        if (rd_en)
            base_q <= rd_addr[BANK_W-1:0];
    end

    // Rotate bank outputs into address order.
    always_comb begin
        for (int k = 0; k < LANES; k++)
            rd_bytes[k] = bank_q[BANK_W'(base_q + BANK_W'(k))];
    end

endmodule

// File: rtl/rxp_swap.sv
// Module rxp_swap
// Packs address-ordered bytes into the output word for the access width,
// reversing lane order in big-endian mode and zeroing unused lanes.
module rxp_swap
    import rxp_pkg::*;
(
    input  logic [LANES-1:0][7:0] bytes,
    input  logic [1:0]            size,
    input  logic                  big_end,
    output logic [LANES*8-1:0]    data
);

    logic [2:0] n;

    // Lane placement per access width and byte order.
    always_comb begin
        n    = size_bytes(size);
        data = '0;
        for (int k = 0; k < LANES; k++) begin
            if (3'(k) < n) begin
                if (big_end)
                    data[8*(int'(n)-1-k) +: 8] = bytes[k];
                else
                    data[8*k +: 8] = bytes[k];
            end
        end
    end

endmodule

// File: rtl/rxp_top.sv
// Module rxp_top
// Host read window into a receive frame buffer with an auto-incrementing
// byte pointer. One read is accepted per cycle with data_rd high, and
// its data appears one cycle later. Assumes the fill side avoids bytes
// being read in the same cycle.
module rxp_top
    import rxp_pkg::*;
#(
    parameter int PTR_W = 11,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             data_rd,
    input  logic [1:0]       data_size,
    output logic [31:0]      data_rdata,
    output logic             data_valid,
    input  logic             buf_we,
    input  logic [PTR_W-1:0] buf_waddr,
    input  logic [7:0]       buf_wdata
);

    localparam int AUTO_BIT = 14;
    localparam int END_BIT  = 11;

    logic [PTR_W-1:0]      ptr;
    logic                  auto_en;
    logic                  big_end;
    logic [LANES-1:0][7:0] rd_bytes;
    logic [1:0]            size_q;
    logic                  end_q;
    logic                  valid_q;
    logic                  unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[REG_W-1:AUTO_BIT+1],
                               cfg_wdata[AUTO_BIT-1:END_BIT+1]};

    rxp_ctrl_reg #(
        .PTR_W(PTR_W), .REG_W(REG_W), .AUTO_BIT(AUTO_BIT), .END_BIT(END_BIT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .wr_ptr   (cfg_wdata[PTR_W-1:0]),
        .wr_auto  (cfg_wdata[AUTO_BIT]),
        .wr_end   (cfg_wdata[END_BIT]),
        .rd_go    (data_rd),
        .rd_size  (data_size),
        .ptr      (ptr),
        .auto_en  (auto_en),
        .big_end  (big_end),
        .cfg_rdata(cfg_rdata)
    );

    rxp_lane_buf #(.PTR_W(PTR_W)) u_buf (
        .clk      (clk),
        .buf_we   (buf_we),
        .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata),
        .rd_en    (data_rd),
        .rd_addr  (ptr),
        .rd_bytes (rd_bytes)
    );

    // Capture read width and byte order alongside the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= SZ_BYTE;
            end_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= data_rd;
            if (data_rd) begin
                size_q <= data_size;
                end_q  <= big_end;
            end
        end
    end

    rxp_swap u_swap (
        .bytes  (rd_bytes),
        .size   (size_q),
        .big_end(end_q),
        .data   (data_rdata)
    );

    assign data_valid = valid_q;

endmodule

// File: rtl/rxp_chk.sv
// Module rxp_chk
// Property checker for rxp_top, attached by bind below.
module rxp_chk #(
    parameter int PTR_W = 11,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             data_rd,
    input logic [1:0]       data_size,
    input logic [31:0]      data_rdata,
    input logic             data_valid,
    input logic [PTR_W-1:0] ptr,
    input logic             auto_en
);

    logic [PTR_W-1:0] inc;

    // Increment expected for the current request width.
    always_comb begin
        inc = (data_size == 2'b01) ? PTR_W'(2) :
              (data_size == 2'b10) ? PTR_W'(4) : PTR_W'(1);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0 && !data_valid && cfg_rdata == '0));

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ptr == $past(cfg_wdata[PTR_W-1:0])
                    && cfg_rdata[14] == $past(cfg_wdata[14])
                    && cfg_rdata[11] == $past(cfg_wdata[11])));

    // R2
    readback_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~16'h4800) == '0);

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> data_valid);

    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> !data_valid);

    // R4
    auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && auto_en && !cfg_wr) |=> ptr == $past(ptr + inc));

    // R5
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !(data_rd && auto_en)) |=> $stable(ptr));

    // R7
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && data_size != 2'b01 && data_size != 2'b10)
            |=> data_rdata[31:8] == '0);

    // R7
    word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && data_size == 2'b01) |=> data_rdata[31:16] == '0);

endmodule

bind rxp_top rxp_chk #(.PTR_W(PTR_W), .REG_W(REG_W)) u_rxp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .data_rd   (data_rd),
    .data_size (data_size),
    .data_rdata(data_rdata),
    .data_valid(data_valid),
    .ptr       (ptr),
    .auto_en   (auto_en)
);

// File: tb/rxp_top_test.sv
`timescale 1ns/1ps
module rxp_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        data_rd = 1'b0;
    logic [1:0]  data_size = 2'b00;
    logic [31:0] data_rdata;
    logic        data_valid;
    logic        buf_we = 1'b0;
    logic [10:0] buf_waddr = '0;
    logic [7:0]  buf_wdata = '0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]  model [2048];
    logic [10:0] m_ptr = '0;
    bit          m_auto = 1'b0;
    bit          m_end = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2.5 clk = ~clk;

    rxp_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .data_rd(data_rd), .data_size(data_size),
        .data_rdata(data_rdata), .data_valid(data_valid), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 5 + (a >> 8) + 8'h3C);
    endfunction

    function automatic logic [31:0] expect_word(input logic [10:0] a,
                                                input logic [1:0] sz,
                                                input bit be);
        int n;
        logic [31:0] w;
        n = (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
        w = '0;
        for (int k = 0; k < n; k++) begin
            if (be) w[8*(n-1-k) +: 8] = model[11'(a + 11'(k))];
            else    w[8*k +: 8]       = model[11'(a + 11'(k))];
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: issue one read at this negedge, record expectation.
    task automatic rd(input logic [1:0] sz, input string tag);
        data_rd   = 1'b1;
        data_size = sz;
        exp_q.push_back(expect_word(m_ptr, sz, m_end));
        tag_q.push_back(tag);
        if (m_auto)
            m_ptr = m_ptr + ((sz == 2'b01) ? 11'd2 : (sz == 2'b10) ? 11'd4 : 11'd1);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        data_rd = 1'b0;
        cfg_wr  = 1'b0;
        buf_we  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [15:0] v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        m_ptr  = v[10:0];
        m_auto = v[14];
        m_end  = v[11];
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Monitor: compare each returned item against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && data_valid) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R3: unexpected data_valid, actual %h expected none",
                         data_rdata);
            end else begin
                check(tag_q.pop_front(), data_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 2048; a++) model[a] = pat(a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the ports
        check("R1 cfg_rdata", {16'h0, cfg_rdata}, 32'h0);
        check("R1 data_valid", {31'h0, data_valid}, 32'h0);

        // Fill the buffer through the write port
        for (int a = 0; a < 2048; a++) begin
            buf_we = 1'b1; buf_waddr = 11'(a); buf_wdata = model[a];
            @(negedge clk);
        end
        idle(1);

        // R1: pointer starts at 0, manual mode (pointer holds)
        rd(2'b00, "R1 first byte");
        rd(2'b00, "R1 second byte held");
        idle(2);

        // R4: auto increment by width, size 11 as byte
        cfg(16'h4000);
        check("R2 readback auto", {16'h0, cfg_rdata}, 32'h4000);
        rd(2'b00, "R4 byte");
        rd(2'b01, "R4 word");
        rd(2'b10, "R4 dword");
        rd(2'b11, "R4 size11");
        rd(2'b00, "R4 after size11");
        idle(2);

        // R5: manual mode holds the pointer
        cfg(16'h0064);
        rd(2'b10, "R5 dword a");
        rd(2'b10, "R5 dword b");
        rd(2'b01, "R5 word c");
        idle(2);

        // R7: big-endian lane order
        cfg(16'h4810);
        rd(2'b01, "R7 be word");
        rd(2'b10, "R7 be dword");
        rd(2'b00, "R7 be byte");
        idle(1);
        cfg(16'h4013);
        rd(2'b10, "R7 le dword unaligned");
        rd(2'b01, "R7 le word");
        idle(2);

        // R6: wrap at the top of the buffer
        cfg(16'h47FE);
        rd(2'b10, "R6 dword across top");
        rd(2'b00, "R6 byte after wrap");
        idle(2);

        // R2: full write, only mode bits read back
        cfg(16'hFFFF);
        check("R2 readback all", {16'h0, cfg_rdata}, 32'h4800);
        rd(2'b01, "R2 word at 7FF be");
        rd(2'b00, "R6 byte after word wrap");
        idle(2);

        // R8: write and read in the same cycle
        cfg(16'h4010);
        cfg_wr = 1'b1; cfg_wdata = 16'h4A00;
        data_rd = 1'b1; data_size = 2'b01;
        exp_q.push_back(expect_word(m_ptr, 2'b01, m_end));
        tag_q.push_back("R8 read uses old state");
        m_ptr = 11'h200; m_auto = 1'b1; m_end = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        rd(2'b01, "R8 next read from written pointer");
        idle(2);

        // R9: new byte from the write port is returned
        buf_we = 1'b1; buf_waddr = 11'd5; buf_wdata = 8'hA5; model[5] = 8'hA5;
        @(negedge clk);
        buf_we = 1'b0;
        cfg(16'h4004);
        rd(2'b10, "R9 dword covering rewritten byte");
        idle(4);

        check("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule